// File: doc/BRIEF.md
# Packed GPIO Configuration Slave

This block is a Wishbone slave that keeps an eight-bit configuration record for each of a parameterised number of GPIO pins. Records are packed one per byte lane, so a single bus word covers as many pins as the bus has select lines. Bus writes update records, and bus reads return them. On the pad side, each pin's output enable, output value, pull-up, pull-down and bank select are driven straight from its stored record. The pin's sampled input is merged into read data.

A record holds output enable in bit 0, input enable in bit 1, pull-up enable in bit 2, pull-down enable in bit 3, a shared io bit in bit 4 and a three-bit bank number in bits 7:5. Writing the io bit sets the pin's output value. Reading it returns the output value when output enable is set, and the sampled pad input otherwise. Input enable is stored and can be read back, but it does not reach the pads. A request is taken when cyc and stb are both high. It is acknowledged by a registered ack on the following clock.

Top module: `gpio_cfg_slave`

## Requirements
- R1: A record byte is laid out as bit 0 oe, bit 1 ie, bit 2 pull-up, bit 3 pull-down, bit 4 io, bits 7:5 bank. The oe, pull-up, pull-down, io (as output value) and bank fields drive pad_oe, pad_pu, pad_pd, pad_o and pad_bank[3p+2:3p] for pin p.
- R2: Byte lane i at word address a maps to pin a*SEL_W+i, where lane i occupies data bits 8i+7:8i.
- R3: A write changes only the records whose select bit is 1. Records in unselected lanes keep their value.
- R4: On a read, a lane whose select bit is 0 returns zero.
- R5: On a read, the io bit of a record returns the output value when oe is 1, and the pad input when oe is 0.
- R6: A request is accepted when cyc and stb are high and ack is low. All request fields are taken in that cycle. ack is high exactly on the following cycle. A request held through its ack cycle is accepted again only on the next cycle.
- R7: wb_dat_r carries the read data only while a read is acknowledged. At all other times it is zero.
- R8: The ie bit is stored and read back, and writing it alone changes no pad output.
- R9: A lane whose pin number is NUM_PINS or more is ignored on writes and reads as zero.
- R10: After reset every record is zero: all pins are inputs, with no pulls and bank 0.
- R11: DATA_W must equal 8*SEL_W, with SEL_W being 1, 2, 4 or 8. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Word address |
| wb_dat_w | input | DATA_W | Write data |
| wb_sel | input | SEL_W | Byte-lane selects |
| wb_dat_r | output | DATA_W | Read data |
| wb_ack | output | 1 | Registered acknowledge |
| pad_i | input | NUM_PINS | Sampled pad inputs |
| pad_oe | output | NUM_PINS | Output enables |
| pad_o | output | NUM_PINS | Output values |
| pad_pu | output | NUM_PINS | Pull-up enables |
| pad_pd | output | NUM_PINS | Pull-down enables |
| pad_bank | output | 3*NUM_PINS | Bank select, three bits per pin |

## Verification
The hardest case to reach is a bus word that is only partly backed by pins. With ten pins on a four-lane bus, the last row has two real lanes and two missing ones. Random select masks must hit such a row while earlier writes have left non-zero records in the neighbouring lanes, so that a leak or a wrongly cleared lane would be visible. The stimulus therefore draws addresses that include that partial row and one row lying wholly beyond the pins. It changes the pad inputs between operations, so the io readback mux is tested with oe in both states.

// File: rtl/gpio_cfg_slave.sv
module gpio_cfg_slave #(
  parameter int NUM_PINS = 10,
  parameter int SEL_W    = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wb_cyc,
  input  logic                  wb_stb,
  input  logic                  wb_we,
  input  logic [ADDR_W-1:0]     wb_adr,
  input  logic [DATA_W-1:0]     wb_dat_w,
  input  logic [SEL_W-1:0]      wb_sel,
  output logic [DATA_W-1:0]     wb_dat_r,
  output logic                  wb_ack,
  input  logic [NUM_PINS-1:0]   pad_i,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_o,
  output logic [NUM_PINS-1:0]   pad_pu,
  output logic [NUM_PINS-1:0]   pad_pd,
  output logic [3*NUM_PINS-1:0] pad_bank
);

  localparam int NUM_ROWS = (NUM_PINS + SEL_W - 1) / SEL_W;

  // R11: bus geometry check at elaboration
  if (DATA_W != 8 * SEL_W || !(SEL_W == 1 || SEL_W == 2 || SEL_W == 4 || SEL_W == 8)) begin : g_bad_cfg
    $error("gpio_cfg_slave: DATA_W must be 8*SEL_W with SEL_W in {1,2,4,8}");
  end

  logic              accept;
  logic [8*NUM_PINS-1:0] rb_flat;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rd_q;

  assign accept = wb_cyc & wb_stb & ~wb_ack;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int ROW  = p / SEL_W;
    localparam int LANE = p % SEL_W;
    logic       hit;
    logic [7:0] rec_q;

    assign hit = accept & wb_we & (wb_adr == ADDR_W'(ROW)) & wb_sel[LANE];

    always_ff @(posedge clk) begin
      if (!rst_n)   rec_q <= '0;
      else if (hit) rec_q <= wb_dat_w[LANE*8 +: 8];
    end

    assign pad_oe[p]          = rec_q[0];
    assign pad_pu[p]          = rec_q[2];
    assign pad_pd[p]          = rec_q[3];
    assign pad_o[p]           = rec_q[4];
    assign pad_bank[3*p +: 3] = rec_q[7:5];
    assign rb_flat[8*p +: 8]  = {rec_q[7:5], rec_q[0] ? rec_q[4] : pad_i[p], rec_q[3:0]};
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (wb_adr == ADDR_W'(p / SEL_W) && wb_sel[p % SEL_W])
        rd_next[(p % SEL_W)*8 +: 8] = rb_flat[8*p +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack <= 1'b0;
      rd_q   <= '0;
    end else begin
      wb_ack <= accept;
      rd_q   <= (accept && !wb_we) ? rd_next : '0;
    end
  end

  assign wb_dat_r = rd_q;

  a_r6_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wb_ack);
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);
  a_r7_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_ack |-> wb_dat_r == '0);
  a_r3_unselected_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wb_we && wb_sel == '0) |=>
      ($stable(pad_oe) && $stable(pad_o) && $stable(pad_pu) && $stable(pad_pd) && $stable(pad_bank)));
  a_r9_outside_rows_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wb_we && wb_adr >= ADDR_W'(NUM_ROWS)) |=>
      ($stable(pad_oe) && $stable(pad_o) && $stable(pad_pu) && $stable(pad_pd) && $stable(pad_bank)));

endmodule

// File: tb/gpio_cfg_slave_tb.sv
module gpio_cfg_slave_tb;
  localparam int N  = 10;
  localparam int SW = 4;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 0, stb = 0, we = 0;
  logic [AW-1:0] adr = '0;
  logic [DW-1:0] dat_w = '0;
  logic [SW-1:0] sel = '0;
  logic [DW-1:0] dat_r;
  logic ack;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] oe, o, pu, pd;
  logic [3*N-1:0] bank;

  logic [7:0] m_rec [N];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  gpio_cfg_slave #(.NUM_PINS(N), .SEL_W(SW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
    .wb_adr(adr), .wb_dat_w(dat_w), .wb_sel(sel), .wb_dat_r(dat_r), .wb_ack(ack),
    .pad_i(pin_i), .pad_oe(oe), .pad_o(o), .pad_pu(pu), .pad_pd(pd), .pad_bank(bank));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [SW-1:0] s);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < SW; i++) begin
      int p = int'(a) * SW + i;
      if (s[i] && p < N) begin
        logic [7:0] b = m_rec[p];
        b[4] = b[0] ? m_rec[p][4] : pin_i[p];
        r[8*i +: 8] = b;
      end
    end
    return r;
  endfunction

  task automatic check_pads(input string req);
    logic [N-1:0] e_oe, e_o, e_pu, e_pd;
    logic [3*N-1:0] e_bank;
    for (int p = 0; p < N; p++) begin
      e_oe[p] = m_rec[p][0]; e_pu[p] = m_rec[p][2]; e_pd[p] = m_rec[p][3];
      e_o[p] = m_rec[p][4]; e_bank[3*p +: 3] = m_rec[p][7:5];
    end
    check({req, " pads"}, {oe, o, pu, pd, bank}, {e_oe, e_o, e_pu, e_pd, e_bank});
  endtask

  task automatic bus_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SW-1:0] s, output logic [DW-1:0] rd);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; dat_w = d; sel = s;
    #1 check("R6 ack low in request cycle", ack, 0);
    @(negedge clk);
    check("R6 ack one cycle later", ack, 1);
    rd = dat_r;
    cyc = 0; stb = 0; we = 0; dat_w = '0;
    if (w) begin
      for (int i = 0; i < SW; i++) begin
        int p = int'(a) * SW + i;
        if (s[i] && p < N) m_rec[p] = d[8*i +: 8];
      end
      check("R7 write ack has zero data", rd, 0);
    end
    @(negedge clk);
    check("R7 data zero after ack", dat_r, 0);
    check("R6 ack drops", ack, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
    logic [DW-1:0] rd;
    bus_op(1, a, d, s, rd);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [SW-1:0] s);
    logic [DW-1:0] rd, e;
    e = exp_read(a, s);
    bus_op(0, a, '0, s, rd);
    check(req, rd, e);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] tmp;
    void'($urandom(1234));
    for (int p = 0; p < N; p++) m_rec[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check_pads("R10 reset");
    check("R10 reset ack", ack, 0);
    pin_i = 10'h3ff;
    rd_chk("R10 R5 reset readback shows inputs", 0, 4'hf);

    // R1 R2: lane mapping and field layout
    wr(1, 32'hE1_12_A5_5D, 4'hf);
    check_pads("R1 R2 row1 write");
    check("R2 pin4 lane0 oe", oe[4], 1);
    check("R1 pin7 bank", bank[21 +: 3], 3'b111);
    // R3: partial select
    wr(1, 32'h00_00_00_00, 4'b0100);
    check_pads("R3 single lane write");
    check("R3 pin7 untouched", bank[21 +: 3], 3'b111);
    // R4: unselected read lanes zero
    rd_chk("R4 partial select read", 1, 4'b1010);
    // R5: io mux both ways
    wr(0, 32'h00_00_11_00, 4'b0011);
    pin_i = 10'h000;
    rd_chk("R5 oe=0 shows input", 0, 4'b0011);
    wr(0, 32'h00_00_11_00 | 32'h00_00_01_00, 4'b0010);
    rd_chk("R5 oe=1 shows output", 0, 4'b0010);
    // R8: ie only, pads unchanged
    wr(2, 32'h00_00_00_02, 4'b0001);
    check_pads("R8 ie write pads");
    check("R8 pin8 oe stays", oe[8], 0);
    rd_chk("R8 ie readback", 2, 4'b0001);
    // R9: lanes beyond pins
    wr(2, 32'hFF_FF_00_00, 4'b1100);
    check_pads("R9 high lanes ignored");
    rd_chk("R9 high lanes read zero", 2, 4'hf);
    wr(3, 32'hFFFF_FFFF, 4'hf);
    check_pads("R9 row beyond pins");
    rd_chk("R9 row beyond reads zero", 3, 4'hf);

    // R6: held request gets ack, gap, ack
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = 1; sel = 4'hf;
    @(negedge clk); check("R6 held ack1", ack, 1);
    @(negedge clk); check("R6 held gap", ack, 0);
    @(negedge clk); check("R6 held ack2", ack, 1);
    cyc = 0; stb = 0;
    @(negedge clk); check("R6 held end", ack, 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 3));
      logic [SW-1:0] s = SW'($urandom);
      pin_i = N'($urandom);
      if ($urandom_range(0, 1)) begin
        wr(a, $urandom, s);
        check_pads("R3 R9 random write");
      end else begin
        rd_chk("R4 R5 random read", a, s);
      end
    end
    tmp = '0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule